// File: doc/BRIEF.md
# Interleaved Multiphase Fire Sequencer

This block decides which power phase of a multiphase buck regulator gets its switching pulse on each tick of a free-running phase clock. It supports two to six phases. For four or more phases it does not walk the phases in plain numeric order. It uses a fixed interleave that depends on the phase count, so that two phases firing one after the other sit far apart on the board. With two or three phases the order is plain rotation.

Each clock, while enabled, the sequencer takes one slot of the order. It raises one bit of a one-hot fire vector for the phase that owns that slot, and it reports that phase number. A per-phase over-current flag enforces a cycle-by-cycle limit. A flagged phase loses only its current slot, and that slot is still used up, so the phases that follow keep their places. A new phase count, or reset, restarts the order at phase 1. A phase count the block cannot use is treated as two phases and flagged.

Top module: `phase_fire_seq`

## Requirements
- R1: After reset, `fire` is all zero and `cur_phase` is 0. The first enabled slot fires phase 1.
- R2: With `ph_count` = 2 the enabled slots fire phases 1, 2, repeating. With `ph_count` = 3 they fire 1, 2, 3, repeating.
- R3: With `ph_count` = 4 the enabled slots fire phases 1, 4, 2, 3, repeating.
- R4: With `ph_count` = 5 the enabled slots fire phases 1, 4, 2, 5, 3, repeating.
- R5: With `ph_count` = 6 the enabled slots fire phases 1, 4, 2, 5, 3, 6, repeating.
- R6: If `oc_flag[k-1]` is high on the clock edge that takes phase k's slot, `fire` stays all zero for that slot and `cur_phase` still shows k. The next slot fires its normal phase. A flag on any other phase has no effect.
- R7: When the effective phase count differs from the one used on the previous edge, that edge fires phase 1.
- R8: `config_error` is high, without delay, whenever `ph_count` is outside 2..6. The block then sequences as two phases.
- R9: At most one bit of `fire` is ever high. An edge with `en` low leaves `fire` all zero, holds `cur_phase`, and does not advance the order.
- R10: Whenever `fire` is non-zero, its single high bit is bit `cur_phase`-1 (bit 0 is phase 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock; each rising edge is one slot |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Sequencing enable |
| ph_count | input | 3 | Configured number of phases (binary) |
| oc_flag | input | 6 | Over-current flag per phase, bit 0 = phase 1 |
| fire | output | 6 | One-hot fire strobe, bit 0 = phase 1 |
| cur_phase | output | 3 | Phase number (1..6) of the latest slot, 0 after reset |
| config_error | output | 1 | Phase count out of range |

## Verification
`fire` and `cur_phase` are registered. The `en`, `ph_count` and `oc_flag` values present at a rising edge show up at these outputs right after that same edge, so the result is due one edge after the stimulus. `config_error` is combinational and is due as soon as `ph_count` changes. The bench drives every input on the falling edge, waits for the next rising edge, and samples one nanosecond later. At that point the registered outputs reflect exactly the slot just taken, and `config_error` still reflects the count that was driven.

// File: rtl/phase_seq_pkg.sv
package phase_seq_pkg;
    localparam int MAX_PHASES = 6;
    localparam int MIN_PHASES = 2;
    localparam int PH_W       = $clog2(MAX_PHASES + 1);
endpackage

// File: rtl/ph_cfg_check.sv
module ph_cfg_check
    import phase_seq_pkg::*;
#(
    parameter int W    = PH_W,
    parameter int LO   = MIN_PHASES,
    parameter int HI   = MAX_PHASES
) (
    input  logic [W-1:0] raw_count,
    output logic [W-1:0] eff_count,
    output logic         bad_count
);
    always_comb begin
        bad_count = (int'(raw_count) < LO) || (int'(raw_count) > HI);
        eff_count = bad_count ? W'(LO) : raw_count;
    end
endmodule

// File: rtl/ph_order_map.sv
module ph_order_map
    import phase_seq_pkg::*;
#(
    parameter int W = PH_W
) (
    input  logic [W-1:0] slot,
    input  logic [W-1:0] count,
    output logic [W-1:0] phase
);
    // Spread-out orders: four phases use 1,4,2,3; five and six use the
    // odd/even split 1,4,2,5,3(,6); two and three rotate plainly.
    always_comb begin
        phase = W'(slot + W'(1));
        case (count)
            W'(4): begin
                case (slot)
                    W'(0):   phase = W'(1);
                    W'(1):   phase = W'(4);
                    W'(2):   phase = W'(2);
                    default: phase = W'(3);
                endcase
            end
            W'(5), W'(6): begin
                if (slot[0]) phase = W'((slot >> 1) + W'(4));
                else         phase = W'((slot >> 1) + W'(1));
            end
            default: phase = W'(slot + W'(1));
        endcase
    end
endmodule

// File: rtl/phase_fire_seq.sv
module phase_fire_seq
    import phase_seq_pkg::*;
#(
    parameter int NPH = MAX_PHASES,
    parameter int CW  = PH_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic [CW-1:0]  ph_count,
    input  logic [NPH-1:0] oc_flag,
    output logic [NPH-1:0] fire,
    output logic [CW-1:0]  cur_phase,
    output logic           config_error
);
    typedef struct packed {
        logic [CW-1:0]  slot;
        logic [CW-1:0]  cnt;
        logic [NPH-1:0] fire;
        logic [CW-1:0]  cur;
    } seq_state_t;

    seq_state_t    st_d, st_q;
    logic [CW-1:0] eff_cnt;
    logic [CW-1:0] slot_use;
    logic [CW-1:0] slot_phase;
    logic [CW-1:0] phase_idx;
    logic          restart;

    ph_cfg_check #(.W(CW), .LO(MIN_PHASES), .HI(NPH)) u_cfg (
        .raw_count (ph_count),
        .eff_count (eff_cnt),
        .bad_count (config_error)
    );

    ph_order_map #(.W(CW)) u_map (
        .slot  (slot_use),
        .count (eff_cnt),
        .phase (slot_phase)
    );

    always_comb begin
        restart   = (eff_cnt != st_q.cnt);
        slot_use  = restart ? '0 : st_q.slot;
        phase_idx = CW'(slot_phase - CW'(1));
        st_d      = st_q;
        st_d.cnt  = eff_cnt;
        st_d.slot = slot_use;
        st_d.fire = '0;
        if (en) begin
            st_d.cur  = slot_phase;
            st_d.slot = (slot_use == CW'(eff_cnt - CW'(1))) ? '0 : CW'(slot_use + CW'(1));
            if (!oc_flag[phase_idx]) st_d.fire[phase_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.slot <= '0;
            st_q.cnt  <= CW'(MIN_PHASES);
            st_q.fire <= '0;
            st_q.cur  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fire      = st_q.fire;
    assign cur_phase = st_q.cur;

    // R9
    fire_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fire));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (fire == '0));

    // R10
    fire_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire != '0) |-> fire[CW'(cur_phase - CW'(1))]);

    // R6
    oc_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (&oc_flag)) |=> (fire == '0));

    // R7
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && restart) |=> (cur_phase == CW'(1)));
endmodule

// File: tb/phase_fire_seq_tb.sv
module phase_fire_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [2:0] ph_count = 3'd2;
    logic [5:0] oc_flag = '0;
    logic [5:0] fire;
    logic [2:0] cur_phase;
    logic       config_error;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    phase_fire_seq u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .ph_count(ph_count),
        .oc_flag(oc_flag), .fire(fire), .cur_phase(cur_phase),
        .config_error(config_error)
    );

    // {count, en, oc_flag, exp_fire, exp_cur, exp_err}
    localparam int NV = 31;
    localparam logic [19:0] VEC [0:NV-1] = '{
        {3'd6, 1'b1, 6'b000000, 6'b000001, 3'd1, 1'b0}, // R7 R5 restart
        {3'd6, 1'b1, 6'b000000, 6'b001000, 3'd4, 1'b0}, // R5
        {3'd6, 1'b1, 6'b000000, 6'b000010, 3'd2, 1'b0}, // R5
        {3'd6, 1'b1, 6'b000000, 6'b010000, 3'd5, 1'b0}, // R5
        {3'd6, 1'b1, 6'b000000, 6'b000100, 3'd3, 1'b0}, // R5
        {3'd6, 1'b1, 6'b000000, 6'b100000, 3'd6, 1'b0}, // R5
        {3'd6, 1'b1, 6'b000010, 6'b000001, 3'd1, 1'b0}, // R6 other flag
        {3'd6, 1'b1, 6'b001000, 6'b000000, 3'd4, 1'b0}, // R6 skip
        {3'd6, 1'b1, 6'b000000, 6'b000010, 3'd2, 1'b0}, // R6 resume
        {3'd6, 1'b0, 6'b000000, 6'b000000, 3'd2, 1'b0}, // R9 idle
        {3'd6, 1'b1, 6'b000000, 6'b010000, 3'd5, 1'b0}, // R9 held
        {3'd4, 1'b1, 6'b000000, 6'b000001, 3'd1, 1'b0}, // R7 R3
        {3'd4, 1'b1, 6'b000000, 6'b001000, 3'd4, 1'b0}, // R3
        {3'd4, 1'b1, 6'b000000, 6'b000010, 3'd2, 1'b0}, // R3
        {3'd4, 1'b1, 6'b000000, 6'b000100, 3'd3, 1'b0}, // R3
        {3'd4, 1'b1, 6'b000000, 6'b000001, 3'd1, 1'b0}, // R3 wrap
        {3'd5, 1'b1, 6'b000000, 6'b000001, 3'd1, 1'b0}, // R7 R4
        {3'd5, 1'b1, 6'b000000, 6'b001000, 3'd4, 1'b0}, // R4
        {3'd5, 1'b1, 6'b000000, 6'b000010, 3'd2, 1'b0}, // R4
        {3'd5, 1'b1, 6'b000000, 6'b010000, 3'd5, 1'b0}, // R4
        {3'd5, 1'b1, 6'b000000, 6'b000100, 3'd3, 1'b0}, // R4
        {3'd5, 1'b1, 6'b000000, 6'b000001, 3'd1, 1'b0}, // R4 wrap
        {3'd3, 1'b1, 6'b000000, 6'b000001, 3'd1, 1'b0}, // R7 R2
        {3'd3, 1'b1, 6'b000000, 6'b000010, 3'd2, 1'b0}, // R2
        {3'd3, 1'b1, 6'b000000, 6'b000100, 3'd3, 1'b0}, // R2
        {3'd3, 1'b1, 6'b000000, 6'b000001, 3'd1, 1'b0}, // R2 wrap
        {3'd2, 1'b1, 6'b000000, 6'b000001, 3'd1, 1'b0}, // R7 R2
        {3'd2, 1'b1, 6'b000000, 6'b000010, 3'd2, 1'b0}, // R2
        {3'd2, 1'b1, 6'b000000, 6'b000001, 3'd1, 1'b0}, // R2 wrap
        {3'd7, 1'b1, 6'b000000, 6'b000010, 3'd2, 1'b1}, // R8 as two
        {3'd0, 1'b1, 6'b000000, 6'b000001, 3'd1, 1'b1}  // R8 as two
    };

    task automatic check(input string req, input logic [5:0] ef,
                         input logic [2:0] ec, input logic ee);
        checks++;
        if (fire !== ef || cur_phase !== ec || config_error !== ee) begin
            errors++;
            $display("FAIL %s: fire=%b cur=%0d err=%b expected fire=%b cur=%0d err=%b",
                     req, fire, cur_phase, config_error, ef, ec, ee);
        end
    endtask

    task automatic step(input logic [2:0] c, input logic e, input logic [5:0] oc);
        @(negedge clk);
        ph_count = c; en = e; oc_flag = oc;
        @(posedge clk);
        #1;
    endtask

    initial begin : watchdog
        #400000;
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #7;
        check("R1 reset", 6'b0, 3'd0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][19:17], VEC[i][16], VEC[i][15:10]);
            check($sformatf("R2-table row %0d", i), VEC[i][9:4], VEC[i][3:1], VEC[i][0]);
        end
        // R8: combinational flag before any edge
        @(negedge clk);
        ph_count = 3'd1; #1;
        checks++;
        if (config_error !== 1'b1) begin
            errors++;
            $display("FAIL R8: config_error=%b expected 1", config_error);
        end
        // R1: reset mid-run, then first slot fires phase 1
        en = 1'b0; ph_count = 3'd2;
        rst_n = 1'b0; #1;
        check("R1 async reset", 6'b0, 3'd0, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        step(3'd2, 1'b1, 6'b0);
        check("R1 first slot", 6'b000001, 3'd1, 1'b0);
        // R6: all flags high over a full six-phase round, order kept
        step(3'd6, 1'b1, 6'b111111);
        check("R6 all blocked p1", 6'b0, 3'd1, 1'b0);
        step(3'd6, 1'b1, 6'b111111);
        check("R6 all blocked p4", 6'b0, 3'd4, 1'b0);
        step(3'd6, 1'b1, 6'b000000);
        check("R6 order kept p2", 6'b000010, 3'd2, 1'b0);
        // R9/R10: enable low while count changes still restarts at phase 1
        step(3'd4, 1'b0, 6'b0);
        check("R9 idle", 6'b0, 3'd2, 1'b0);
        step(3'd4, 1'b1, 6'b0);
        check("R10 restart after idle", 6'b000001, 3'd1, 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule